// File: doc/BRIEF.md
# Dual-Clock Queue with Occupancy Counts

This block carries data words from one clock domain to another through a small queue. The producer side offers a word by raising a push strobe and sees a ready flag. The consumer side sees a valid flag and the word at the head of the queue, first-word-fall-through style, and removes that word with a pop strobe. Each side also has an occupancy count. The count on each side is computed from its own pointer and a synchronised copy of the other side's pointer, so it trails the far side's activity by the two-flop synchroniser latency.

Pointers are Gray coded and carry one extra wrap bit before they cross domains. The requested depth is rounded up to a power of two. A build-time option adds one registered output stage after the storage array. With that stage the usable depth is a power of two plus one, and the head word comes from a flop instead of the array. A strict-depth option turns any rounding into an elaboration error, as does a request that is too small to build.

Top module: `fifo_cdc_top`

## Requirements
- R1: Without the output stage, the queue accepts exactly the requested depth rounded up to the next power of two (a request of 10 holds 16 words). Requests below 2 are rejected.
- R2: With the output stage, the queue accepts the next power of two at or above (request − 1), plus one (a request of 5 holds 5 words, a request of 4 holds 5). `rd_count` then includes the word held in the output stage.
- R3: `wr_ready` is low whenever the array holds its full power-of-two count as seen from the write side, and `wr_count` never exceeds that count. A push offered while `wr_ready` is low stores nothing and is never read out.
- R4: Words are read out in the order they were accepted, with their values intact, whatever the relative speed of the two clocks.
- R5: With both sides on one clock and no pops, `wr_count` equals i right after the i-th consecutive accepted push, and `rd_count` equals i−2 (never below 0). `rd_count` never exceeds the usable depth.
- R6: `rd_valid` is low in any cycle in which `wr_rst` is high.
- R7: A pop offered while `rd_valid` is low has no effect. Whenever `rd_valid` is high, `rd_count` is non-zero.
- R8: After both resets, `rd_valid` is 0, `wr_ready` is 1 and both counts are 0.
- R9: While `rd_valid` is high and no pop is offered, `rd_data` holds its value into the next read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer synchronous reset, active high |
| wr_push | input | 1 | Offer `wr_data` to the queue |
| wr_data | input | DATA_W | Word to enqueue |
| wr_ready | output | 1 | Queue can accept a word this cycle |
| wr_count | output | LVL_W | Occupancy as seen by the producer |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer synchronous reset, active high |
| rd_pop | input | 1 | Remove the head word |
| rd_valid | output | 1 | Head word present on `rd_data` |
| rd_data | output | DATA_W | Head word |
| rd_count | output | LVL_W | Occupancy as seen by the consumer |

## Verification
The outputs show a corrupt pointer or synchroniser state in different ways. A write pointer that skips or repeats shows up at the first read of the affected slot, as a wrong `rd_data` value compared against the ordered scoreboard. A wrong full comparison lets a refused word slip in, which appears as an extra word when the queue is drained. A lost synchroniser stage moves `rd_count` earlier by a cycle in the same-clock latency walk, which is checked after every push. An output-stage fault shows either as a usable depth other than five on the buffered instance or as a head word that changes while no pop is offered.

// File: rtl/fifo_cdc_pkg.sv
package fifo_cdc_pkg;

  // smallest power of two not below n (n >= 1)
  function automatic int pow2_ceil(input int n);
    int p;
    p = 1;
    for (int k = 0; k < 31; k++)
      if (p < n) p = p << 1;
    return p;
  endfunction

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction

  // storage array size; the output stage takes one slot of the request
  function automatic int array_depth(input int req, input bit with_stage);
    int p;
    p = pow2_ceil(with_stage ? req - 1 : req);
    if (p < 2) p = 2;
    return p;
  endfunction

endpackage

// File: rtl/fifo_cdc_sync2.sv
module fifo_cdc_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_cdc_core.sv
module fifo_cdc_core #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_push,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic [AW:0]   wr_count,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_pop,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   rd_count
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  // full: wrap bit and next bit inverted, the rest equal
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (PW - 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx, rgray_at_w;
  logic [PW-1:0] rbin, rgray, rbin_nx, wgray_at_r;
  logic          do_push, do_pop;

  // ---------------- write domain
  assign wr_ready = ((wgray ^ rgray_at_w) != FULL_MASK);
  assign do_push  = wr_push & wr_ready;
  assign wbin_nx  = wbin + PW'(1);

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (do_push) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (do_push) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign wr_count = wbin - g2b(rgray_at_w);

  fifo_cdc_sync2 #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_at_w)
  );

  // ---------------- read domain
  assign rd_valid = (rgray != wgray_at_r);
  assign do_pop   = rd_pop & rd_valid;
  assign rbin_nx  = rbin + PW'(1);

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (do_pop) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  assign rd_data  = mem[rbin[AW-1:0]];
  assign rd_count = g2b(wgray_at_r) - rbin;

  fifo_cdc_sync2 #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_at_r)
  );
endmodule

// File: rtl/fifo_cdc_obuf.sv
module fifo_cdc_obuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  output logic          up_take,
  input  logic          dn_pop,
  output logic          dn_valid,
  output logic [DW-1:0] dn_data
);
  // refill when empty or when the held word leaves this cycle
  assign up_take = up_valid & (~dn_valid | dn_pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
    end else if (up_take) begin
      dn_valid <= 1'b1;
    end else if (dn_pop) begin
      dn_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (up_take) dn_data <= up_data;
  end
endmodule

// File: rtl/fifo_cdc_top.sv
module fifo_cdc_top
  import fifo_cdc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REQ_DEPTH = 10,
  parameter bit BUFFERED  = 1'b0,
  parameter bit EXACT     = 1'b0,
  localparam int CORE_DEPTH = array_depth(REQ_DEPTH, BUFFERED),
  localparam int EFF_DEPTH  = CORE_DEPTH + (BUFFERED ? 1 : 0),
  localparam int AW         = $clog2(CORE_DEPTH),
  localparam int LVL_W      = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_push,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [LVL_W-1:0]  wr_count,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  rd_count
);
  if (BUFFERED ? (REQ_DEPTH < 3) : (REQ_DEPTH < 2)) begin : g_too_small
    $error("fifo_cdc_top: REQ_DEPTH too small for this variant");
  end
  if (EXACT && !is_pow2(BUFFERED ? REQ_DEPTH - 1 : REQ_DEPTH)) begin : g_not_exact
    $error("fifo_cdc_top: REQ_DEPTH would be rounded but EXACT is set");
  end

  logic              core_valid, core_pop;
  logic [DATA_W-1:0] core_data;
  logic [LVL_W-1:0]  core_rcount;
  logic              head_valid;

  fifo_cdc_core #(.DW(DATA_W), .AW(AW)) u_core (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_push(wr_push), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_count(wr_count),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_pop(core_pop),
    .rd_valid(core_valid), .rd_data(core_data), .rd_count(core_rcount)
  );

  // a producer reset hides the head word at once
  assign rd_valid = head_valid & ~wr_rst;

  if (BUFFERED) begin : g_stage
    logic stage_valid;

    fifo_cdc_obuf #(.DW(DATA_W)) u_obuf (
      .clk(rd_clk), .rst(rd_rst),
      .up_valid(core_valid), .up_data(core_data), .up_take(core_pop),
      .dn_pop(rd_pop & rd_valid), .dn_valid(stage_valid), .dn_data(rd_data)
    );
    assign head_valid = stage_valid;
    assign rd_count   = core_rcount + LVL_W'(stage_valid);
  end else begin : g_direct
    assign head_valid = core_valid;
    assign core_pop   = rd_pop & rd_valid;
    assign rd_data    = core_data;
    assign rd_count   = core_rcount;
  end
endmodule

// File: rtl/fifo_cdc_chk.sv
module fifo_cdc_chk #(
  parameter int DW         = 8,
  parameter int CORE_DEPTH = 16,
  parameter int EFF_DEPTH  = 16,
  parameter int LVL_W      = 5
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             wr_ready,
  input logic [LVL_W-1:0] wr_count,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             rd_pop,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data,
  input logic [LVL_W-1:0] rd_count
);
  // R3
  wr_count_cap_chk: assert property (@(posedge wr_clk) disable iff (wr_rst || rd_rst)
    int'(wr_count) <= CORE_DEPTH);

  // R3
  full_blocks_chk: assert property (@(posedge wr_clk) disable iff (wr_rst || rd_rst)
    (int'(wr_count) == CORE_DEPTH) |-> !wr_ready);

  // R5
  rd_count_cap_chk: assert property (@(posedge rd_clk) disable iff (wr_rst || rd_rst)
    int'(rd_count) <= EFF_DEPTH);

  // R6
  hidden_in_wrst_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    wr_rst |-> !rd_valid);

  // R7
  valid_has_count_chk: assert property (@(posedge rd_clk) disable iff (wr_rst || rd_rst)
    rd_valid |-> (rd_count != '0));

  // R9
  head_hold_chk: assert property (@(posedge rd_clk) disable iff (wr_rst || rd_rst)
    (rd_valid && !rd_pop) |=> $stable(rd_data));
endmodule

bind fifo_cdc_top fifo_cdc_chk #(
  .DW(DATA_W), .CORE_DEPTH(CORE_DEPTH), .EFF_DEPTH(EFF_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_ready(wr_ready), .wr_count(wr_count),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_pop(rd_pop), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_count(rd_count)
);

// File: tb/fifo_cdc_top_tb.sv
module fifo_cdc_top_tb;
  logic clk = 1'b0;
  logic rclk2 = 1'b0;
  always #10 clk = ~clk;     // 50 MHz
  always #17 rclk2 = ~rclk2; // unrelated consumer clock for the staged instance

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // instance A: no output stage, one clock for both sides
  logic       a_wrst, a_rrst, a_push, a_wready, a_pop, a_rvalid;
  logic [7:0] a_wdata, a_rdata;
  logic [4:0] a_wcount, a_rcount;

  fifo_cdc_top #(.DATA_W(8), .REQ_DEPTH(10), .BUFFERED(1'b0)) u_dut (
    .wr_clk(clk), .wr_rst(a_wrst), .wr_push(a_push), .wr_data(a_wdata),
    .wr_ready(a_wready), .wr_count(a_wcount),
    .rd_clk(clk), .rd_rst(a_rrst), .rd_pop(a_pop), .rd_valid(a_rvalid),
    .rd_data(a_rdata), .rd_count(a_rcount)
  );

  // instance B: with output stage, separate clocks
  logic       b_wrst, b_rrst, b_push, b_wready, b_pop, b_rvalid;
  logic [7:0] b_wdata, b_rdata;
  logic [2:0] b_wcount, b_rcount;

  fifo_cdc_top #(.DATA_W(8), .REQ_DEPTH(5), .BUFFERED(1'b1)) u_dut_buf (
    .wr_clk(clk), .wr_rst(b_wrst), .wr_push(b_push), .wr_data(b_wdata),
    .wr_ready(b_wready), .wr_count(b_wcount),
    .rd_clk(rclk2), .rd_rst(b_rrst), .rd_pop(b_pop), .rd_valid(b_rvalid),
    .rd_data(b_rdata), .rd_count(b_rcount)
  );

  logic [7:0] qa[$];
  logic [7:0] qb[$];

  function automatic int exp_depth(input int req, input bit staged);
    int p;
    p = 1;
    while (p < (staged ? req - 1 : req)) p = p * 2;
    return staged ? p + 1 : p;
  endfunction

  function automatic int exp_rlag(input int i);
    return (i > 2) ? i - 2 : 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    a_wrst = 1; a_rrst = 1; a_push = 0; a_pop = 0; a_wdata = 0;
    b_wrst = 1; b_rrst = 1; b_push = 0; b_pop = 0; b_wdata = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    a_wrst = 0; a_rrst = 0; b_wrst = 0; b_rrst = 0;
    #1;
    // R8 reset state
    chk("R8", "A rd_valid", a_rvalid, 0);
    chk("R8", "A wr_ready", a_wready, 1);
    chk("R8", "A wr_count", a_wcount, 0);
    chk("R8", "A rd_count", a_rcount, 0);
    chk("R8", "B rd_valid", b_rvalid, 0);
    chk("R8", "B rd_count", b_rcount, 0);

    // R5 count lag on a shared clock
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      a_push = 1; a_wdata = 8'(i);
      @(posedge clk);
      #5;
      chk("R5", $sformatf("rd_count after push %0d", i), a_rcount, exp_rlag(i));
      chk("R5", $sformatf("wr_count after push %0d", i), a_wcount, i);
    end

    // R1 fill to capacity, R3 refused pushes
    n = 10;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (a_wready) begin
        n++;
        a_push = 1; a_wdata = 8'(n);
      end else begin
        a_push = 1; a_wdata = 8'hEE;
      end
    end
    @(negedge clk);
    a_push = 0;
    chk("R1", "accepted words", n, exp_depth(10, 1'b0));
    chk("R3", "wr_ready when full", a_wready, 0);
    chk("R3", "wr_count when full", a_wcount, 16);
    repeat (3) @(negedge clk);
    chk("R5", "rd_count settled", a_rcount, 16);

    // R4 ordered drain, R3 nothing extra stored
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      a_pop = 1;
      #1;
      chk("R4", "drain rd_valid", a_rvalid, 1);
      chk("R4", $sformatf("drain word %0d", k), a_rdata, k);
    end
    @(negedge clk);
    a_pop = 0;
    #1;
    chk("R3", "empty after drain", a_rvalid, 0);

    // R7 pop on empty ignored
    repeat (5) begin
      @(negedge clk);
      a_pop = 1;
    end
    @(negedge clk);
    a_pop = 0; a_push = 1; a_wdata = 8'hA5;
    @(negedge clk);
    a_push = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R7", "rd_valid after late push", a_rvalid, 1);
    chk("R7", "rd_count after late push", a_rcount, 1);
    chk("R7", "head word", a_rdata, 8'hA5);
    // R9 head held without pop
    repeat (3) begin
      @(negedge clk);
      chk("R9", "held head", a_rdata, 8'hA5);
    end
    @(negedge clk);
    a_pop = 1;
    @(negedge clk);
    a_pop = 0;
    #1;
    chk("R7", "empty after single pop", a_rvalid, 0);

    // R4 random traffic on instance A
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      a_push  = ($urandom % 100) < 55;
      a_wdata = 8'($urandom);
      a_pop   = ($urandom % 100) < 50;
      #1;
      if (a_pop && a_rvalid) chk("R4", "random A word", a_rdata, qa.pop_front());
      if (a_push && a_wready) qa.push_back(a_wdata);
    end
    @(negedge clk);
    a_push = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      a_pop = 1;
      #1;
      if (a_rvalid) chk("R4", "random A tail word", a_rdata, qa.pop_front());
    end
    @(negedge clk);
    a_pop = 0;
    chk("R4", "A scoreboard left", qa.size(), 0);

    // R6 producer reset hides head word
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      a_push = 1; a_wdata = 8'(k + 50);
    end
    @(negedge clk);
    a_push = 0;
    repeat (4) @(negedge clk);
    chk("R6", "rd_valid before reset", a_rvalid, 1);
    a_wrst = 1;
    #1;
    chk("R6", "rd_valid in wr_rst", a_rvalid, 0);
    repeat (2) @(negedge clk);
    chk("R6", "rd_valid in wr_rst later", a_rvalid, 0);
    a_rrst = 1;
    repeat (4) @(negedge clk);
    a_wrst = 0; a_rrst = 0;
    #1;
    chk("R8", "A rd_count after reset", a_rcount, 0);
    chk("R8", "A wr_count after reset", a_wcount, 0);
    chk("R8", "A wr_ready after reset", a_wready, 1);

    // R2 staged capacity with consumer idle
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (b_wready) begin
        n++;
        b_push = 1; b_wdata = 8'(n);
        qb.push_back(8'(n));
      end else begin
        b_push = 1; b_wdata = 8'hEE;
      end
    end
    @(negedge clk);
    b_push = 0;
    chk("R2", "staged accepted words", n, exp_depth(5, 1'b1));
    repeat (4) @(negedge rclk2);
    chk("R2", "staged rd_count", b_rcount, 5);
    chk("R2", "staged head word", b_rdata, 1);
    chk("R3", "staged wr_ready full", b_wready, 0);

    // R4 random traffic across unrelated clocks
    fork
      begin
        for (int c = 0; c < 2500; c++) begin
          @(negedge clk);
          b_push  = ($urandom % 100) < 45;
          b_wdata = 8'($urandom);
          #1;
          if (b_push && b_wready) qb.push_back(b_wdata);
        end
        @(negedge clk);
        b_push = 0;
      end
      begin
        for (int c = 0; c < 1700; c++) begin
          @(negedge rclk2);
          b_pop = ($urandom % 100) < 65;
          #1;
          if (b_pop && b_rvalid) chk("R4", "staged word", b_rdata, qb.pop_front());
        end
        for (int c = 0; c < 60; c++) begin
          @(negedge rclk2);
          b_pop = 1;
          #1;
          if (b_rvalid) chk("R4", "staged tail word", b_rdata, qb.pop_front());
        end
        @(negedge rclk2);
        b_pop = 0;
      end
    join
    chk("R4", "B scoreboard left", qb.size(), 0);
    chk("R4", "B empty at end", b_rvalid, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule